// File: doc/BRIEF.md
# SPI Burst Register and FIFO Access Slave

This block is a serial slave that works in clock mode 0: data is sampled on the rising SCK edge and changed on the falling edge. It lets an external controller reach a 256-location register space and two FIFO ports through short burst transactions. SCK, the active-low select and MOSI are brought into the system clock domain through a synchroniser chain. Edges are then detected on the system clock, so the serial clock must run well below the system clock.

Each transaction opens with a two-byte header. The first byte carries a direction flag and a burst length. The second byte carries the start address. A write then streams the data bytes in. A read returns one byte for each select-low window: select must rise before every data byte, and the block uses that gap to fetch the byte. Two addresses are fixed FIFO ports, one for the transmit side and the one above it for the receive side. A burst that starts on either of them stays there. A register burst that crosses them jumps over both.

Top module: `spi_burst_slave`

## Requirements
- R1: Every byte travels most significant bit first. The first header byte holds the direction in bit 7 (1 = read, 0 = write) and the length N in bits 6:0. The second header byte is the start address.
- R2: A write to a register address produces N single-cycle `reg_wr` pulses. Each pulse carries the received byte on `wr_data` and the target address on `reg_addr`, and the address advances by one after each byte.
- R3: A read from a register address produces one `reg_rd` pulse for each data byte. The byte returned is `reg_rdata` as sampled in that pulse cycle. It is shifted out on `spi_miso`, and its MSB is valid within the synchroniser delay after select falls.
- R4: When a register burst would step onto FIFO_BASE or FIFO_BASE+1 (0x80/0x81 by default), it continues at FIFO_BASE+2 instead. No register strobe is ever issued for either FIFO address.
- R5: A write burst that starts at FIFO_BASE produces N `txf_push` pulses. A read burst that starts at FIFO_BASE+1 produces N `rxf_pop` pulses and returns `rxf_rdata`. In both cases the address does not change during the burst.
- R6: Writes aimed at the receive FIFO address produce no strobe at all. Reads aimed at the transmit FIFO address return 0x00 and produce no strobe.
- R7: A header whose length field is 0 is dropped, and the next byte is decoded as a new header.
- R8: During a write, select may rise between any two bytes without ending the transaction. If select rises in the middle of a byte, the bits received so far are discarded.
- R9: Once N data bytes have been transferred, the next byte is decoded as a new header, even when select stayed low throughout.
- R10: After reset, `spi_miso` is 0 and no strobe is active.
- R11: A register burst wraps from address 0xFF to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| spi_sck | input | 1 | Serial clock, idle low |
| spi_ss_n | input | 1 | Slave select, active low |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out, 0 when not driving a read byte |
| reg_addr | output | 8 | Current target address |
| reg_wr | output | 1 | Register write strobe |
| wr_data | output | 8 | Write data for the register bank and the transmit FIFO |
| reg_rd | output | 1 | Register read strobe |
| reg_rdata | input | 8 | Register read data, valid in the `reg_rd` cycle |
| txf_push | output | 1 | Transmit FIFO push strobe |
| rxf_pop | output | 1 | Receive FIFO pop strobe |
| rxf_rdata | input | 8 | Receive FIFO head data, valid in the `rxf_pop` cycle |

## Verification
The bench builds the block with SYNC_STAGES = 3 and FIFO_BASE left at 0x80. The deeper synchroniser tests the claim that the read fetch completes before select returns low and that MISO settles within a serial half period. The default FIFO base lets the random register bursts, which use start addresses spread over all 256 locations, run into the skip near 0x7E to 0x83 and into the wrap at 0xFF. Directed cases cover the remaining ones: a zero length, back-to-back headers, a select abort in mid-byte, and each direction against each FIFO port.

// File: rtl/spi_burst_slave.sv
module spi_burst_slave #(
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] FIFO_BASE   = 8'h80
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spi_sck,
  input  logic       spi_ss_n,
  input  logic       spi_mosi,
  output logic       spi_miso,
  output logic [7:0] reg_addr,
  output logic       reg_wr,
  output logic [7:0] wr_data,
  output logic       reg_rd,
  input  logic [7:0] reg_rdata,
  output logic       txf_push,
  output logic       rxf_pop,
  input  logic [7:0] rxf_rdata
);
  localparam logic [7:0] TXF_ADDR = FIFO_BASE;
  localparam logic [7:0] RXF_ADDR = FIFO_BASE + 8'd1;
  localparam logic [7:0] SKIP_TO  = FIFO_BASE + 8'd2;

  typedef enum logic [1:0] {S_CMD, S_ADDR, S_WR, S_RD} st_t;

  logic [SYNC_STAGES:0]   sck_p;
  logic [SYNC_STAGES-1:0] ss_p, mosi_p;
  st_t        st;
  logic [2:0] bitcnt;
  logic [6:0] rx_sh;
  logic [7:0] tx_sh;
  logic [6:0] left;
  logic [7:0] addr;
  logic       is_rd, fifo_mode, fetch;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_p  <= '0;
      ss_p   <= '1;
      mosi_p <= '0;
    end else begin
      sck_p  <= {sck_p[SYNC_STAGES-1:0], spi_sck};
      ss_p   <= {ss_p[SYNC_STAGES-2:0], spi_ss_n};
      mosi_p <= {mosi_p[SYNC_STAGES-2:0], spi_mosi};
    end

  wire       ss_act    = ~ss_p[SYNC_STAGES-1];
  wire       mosi_s    = mosi_p[SYNC_STAGES-1];
  wire       sck_rise  = sck_p[SYNC_STAGES-1] & ~sck_p[SYNC_STAGES];
  wire       sck_fall  = ~sck_p[SYNC_STAGES-1] & sck_p[SYNC_STAGES];
  wire       sample    = ss_act & sck_rise;
  wire       byte_done = sample & (bitcnt == 3'd7);
  wire [7:0] rx_byte   = {rx_sh, mosi_s};
  wire       at_fifo   = (addr == TXF_ADDR) || (addr == RXF_ADDR);
  wire [7:0] addr_inc  = addr + 8'd1;
  wire [7:0] next_addr = fifo_mode ? addr :
                         ((addr_inc == TXF_ADDR) || (addr_inc == RXF_ADDR)) ? SKIP_TO : addr_inc;
  wire [7:0] fetch_data = (addr == RXF_ADDR) ? rxf_rdata :
                          (addr == TXF_ADDR) ? 8'h00 : reg_rdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bitcnt <= '0;
      rx_sh  <= '0;
    end else if (!ss_act) begin
      bitcnt <= '0;
    end else if (sample) begin
      bitcnt <= bitcnt + 3'd1;
      rx_sh  <= {rx_sh[5:0], mosi_s};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st        <= S_CMD;
      left      <= '0;
      addr      <= '0;
      is_rd     <= 1'b0;
      fifo_mode <= 1'b0;
      fetch     <= 1'b0;
    end else begin
      fetch <= 1'b0;
      if (byte_done) begin
        unique case (st)
          S_CMD: begin
            is_rd <= rx_byte[7];
            left  <= rx_byte[6:0];
            if (rx_byte[6:0] != 7'd0) st <= S_ADDR;
          end
          S_ADDR: begin
            addr      <= rx_byte;
            fifo_mode <= (rx_byte == TXF_ADDR) || (rx_byte == RXF_ADDR);
            st        <= is_rd ? S_RD : S_WR;
            fetch     <= is_rd;
          end
          S_WR, S_RD: begin
            addr <= next_addr;
            left <= left - 7'd1;
            if (left == 7'd1) st <= S_CMD;
            else fetch <= (st == S_RD);
          end
          default: st <= S_CMD;
        endcase
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tx_sh <= '0;
    else if (fetch) tx_sh <= fetch_data;
    else if (ss_act && sck_fall && bitcnt != 3'd0 && st == S_RD) tx_sh <= {tx_sh[6:0], 1'b0};

  assign spi_miso = ss_act & (st == S_RD) & tx_sh[7];
  assign reg_addr = addr;
  assign wr_data  = rx_byte;
  assign reg_wr   = byte_done & (st == S_WR) & ~at_fifo;
  assign txf_push = byte_done & (st == S_WR) & (addr == TXF_ADDR);
  assign reg_rd   = fetch & ~at_fifo;
  assign rxf_pop  = fetch & (addr == RXF_ADDR);

  assert_one_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_wr, reg_rd, txf_push, rxf_pop}));

  assert_no_bank_at_fifo_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr || reg_rd) |-> (reg_addr != TXF_ADDR && reg_addr != RXF_ADDR));

  assert_fifo_addr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (txf_push || rxf_pop) |=> $stable(reg_addr));

  assert_read_only_in_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd || rxf_pop) |-> (st == S_RD && is_rd));

  assert_zero_len_dropped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CMD && byte_done && rx_byte[6:0] == 7'd0) |=> (st == S_CMD));
endmodule

// File: tb/spi_burst_slave_tb.sv
`timescale 1ns/1ps
module spi_burst_slave_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic spi_sck = 1'b0, spi_ss_n = 1'b1, spi_mosi = 1'b0;
  logic spi_miso, reg_wr, reg_rd, txf_push, rxf_pop;
  logic [7:0] reg_addr, wr_data, reg_rdata, rxf_rdata;

  always #2.5 clk = ~clk;

  spi_burst_slave #(.SYNC_STAGES(3), .FIFO_BASE(8'h80)) dut_i (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_ss_n(spi_ss_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .reg_addr(reg_addr), .reg_wr(reg_wr), .wr_data(wr_data),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata), .txf_push(txf_push), .rxf_pop(rxf_pop),
    .rxf_rdata(rxf_rdata));

  logic [7:0] bank [256];
  logic [7:0] exp_bank [256];
  logic [7:0] txq [256];
  logic [7:0] wdat [128];
  logic [7:0] rdat [128];
  int n_wr = 0, n_rd = 0, n_push = 0, n_pop = 0;
  int vectors = 0, fails = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) bank[i] <= 8'(i) ^ 8'hA5;
    end else begin
      if (reg_wr) bank[reg_addr] <= wr_data;
      if (txf_push) txq[n_push[7:0]] <= wr_data;
      if (reg_wr) n_wr <= n_wr + 1;
      if (reg_rd) n_rd <= n_rd + 1;
      if (txf_push) n_push <= n_push + 1;
      if (rxf_pop) n_pop <= n_pop + 1;
    end
  end
  assign reg_rdata = bank[reg_addr];
  assign rxf_rdata = 8'h40 + n_pop[7:0];

  function automatic logic [7:0] step(input logic [7:0] a);
    logic [7:0] b;
    b = a + 8'd1;
    if (b == 8'h80 || b == 8'h81) b = 8'h82;
    return b;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic half();
    repeat (6) @(negedge clk);
  endtask

  task automatic sel(input logic lvl);
    spi_ss_n = lvl;
    half();
    half();
  endtask

  task automatic xfer(input logic [7:0] o, output logic [7:0] i);
    for (int b = 7; b >= 0; b--) begin
      spi_mosi = o[b];
      half();
      i[b] = spi_miso;
      spi_sck = 1'b1;
      half();
      spi_sck = 1'b0;
    end
    half();
  endtask

  task automatic wr_burst(input logic [7:0] a, input int n, input bit gaps);
    logic [7:0] junk, p;
    sel(1'b0);
    xfer({1'b0, 7'(n)}, junk);
    if (gaps) begin sel(1'b1); sel(1'b0); end
    xfer(a, junk);
    for (int k = 0; k < n; k++) begin
      if (gaps) begin sel(1'b1); sel(1'b0); end
      xfer(wdat[k], junk);
    end
    sel(1'b1);
    p = a;
    for (int k = 0; k < n; k++) begin
      if (p != 8'h80 && p != 8'h81) begin
        exp_bank[p] = wdat[k];
        p = step(p);
      end
    end
  endtask

  task automatic rd_burst(input logic [7:0] a, input int n);
    logic [7:0] junk;
    sel(1'b0);
    xfer({1'b1, 7'(n)}, junk);
    sel(1'b1);
    sel(1'b0);
    xfer(a, junk);
    for (int k = 0; k < n; k++) begin
      sel(1'b1);
      sel(1'b0);
      xfer(8'h00, rdat[k]);
    end
    sel(1'b1);
  endtask

  task automatic rd_check(input logic [7:0] a, input int n, input string req);
    logic [7:0] p;
    rd_burst(a, n);
    p = a;
    for (int k = 0; k < n; k++) begin
      check(rdat[k] == exp_bank[p], req, rdat[k], exp_bank[p]);
      p = step(p);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int unsigned seed_v;
    int c0, c1, c2, c3;
    logic [7:0] junk;
    seed_v = $urandom(32'd4711);
    for (int i = 0; i < 256; i++) exp_bank[i] = 8'(i) ^ 8'hA5;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);

    // R10: reset state
    check(spi_miso == 1'b0, "R10 miso", spi_miso, 0);
    check((n_wr + n_rd + n_push + n_pop) == 0, "R10 strobes", n_wr + n_rd + n_push + n_pop, 0);

    // R2 R4: write across the FIFO hole, R3 R1 read back
    wdat[0] = 8'h11; wdat[1] = 8'h22; wdat[2] = 8'h33; wdat[3] = 8'h44;
    wr_burst(8'h7E, 4, 1'b0);
    check(bank[8'h82] == 8'h33, "R4 skip write", bank[8'h82], 8'h33);
    check(bank[8'h80] == (8'h80 ^ 8'hA5), "R4 fifo addr untouched", bank[8'h80], 8'h80 ^ 8'hA5);
    rd_check(8'h7F, 3, "R3 R4 R1 read skip");

    // R5: transmit FIFO push, address holds
    c0 = n_push; c1 = n_wr;
    wdat[0] = 8'hC1; wdat[1] = 8'hC2; wdat[2] = 8'hC3;
    wr_burst(8'h80, 3, 1'b0);
    check(n_push - c0 == 3, "R5 push count", n_push - c0, 3);
    check(txq[c0[7:0] + 8'd2] == 8'hC3, "R5 push data", txq[c0[7:0] + 8'd2], 8'hC3);
    check(n_wr == c1, "R5 no reg write", n_wr - c1, 0);

    // R5: receive FIFO pops
    c0 = n_pop; c1 = n_rd;
    rd_burst(8'h81, 3);
    check(rdat[0] == 8'h40 + 8'(c0) && rdat[2] == 8'h42 + 8'(c0), "R5 pop data", rdat[2], 8'h42 + 8'(c0));
    check(n_pop - c0 == 3 && n_rd == c1, "R5 pop count", n_pop - c0, 3);

    // R6: write to receive FIFO ignored, read of transmit FIFO gives zero
    c0 = n_wr; c1 = n_push; c2 = n_pop; c3 = n_rd;
    wdat[0] = 8'hEE; wdat[1] = 8'hEF;
    wr_burst(8'h81, 2, 1'b1);
    check(n_wr == c0 && n_push == c1 && n_pop == c2, "R6 write rx fifo strobes", n_wr + n_push + n_pop, c0 + c1 + c2);
    rd_burst(8'h80, 1);
    check(rdat[0] == 8'h00, "R6 read tx fifo data", rdat[0], 0);
    check(n_rd == c3 && n_pop == c2, "R6 read tx fifo strobes", n_rd - c3, 0);

    // R7: zero-length header dropped, next byte is a header
    sel(1'b0);
    xfer(8'h00, junk); xfer(8'h01, junk); xfer(8'h20, junk); xfer(8'h5A, junk);
    sel(1'b1);
    exp_bank[8'h20] = 8'h5A;
    check(bank[8'h20] == 8'h5A, "R7 zero length", bank[8'h20], 8'h5A);

    // R9: back-to-back transactions under one select
    sel(1'b0);
    xfer(8'h01, junk); xfer(8'h30, junk); xfer(8'h11, junk);
    xfer(8'h01, junk); xfer(8'h31, junk); xfer(8'h22, junk);
    sel(1'b1);
    exp_bank[8'h30] = 8'h11; exp_bank[8'h31] = 8'h22;
    check(bank[8'h30] == 8'h11 && bank[8'h31] == 8'h22, "R9 back to back", bank[8'h31], 8'h22);

    // R8: partial byte discarded, then gapped write
    sel(1'b0);
    for (int b = 0; b < 3; b++) begin
      spi_mosi = 1'b1; half(); spi_sck = 1'b1; half(); spi_sck = 1'b0;
    end
    sel(1'b1);
    wdat[0] = 8'h9C; wdat[1] = 8'h3D;
    wr_burst(8'h40, 2, 1'b1);
    check(bank[8'h40] == 8'h9C && bank[8'h41] == 8'h3D, "R8 abort and gaps", bank[8'h41], 8'h3D);

    // R11: wrap at top of address space
    wdat[0] = 8'hA0; wdat[1] = 8'hA1; wdat[2] = 8'hA2;
    wr_burst(8'hFE, 3, 1'b0);
    check(bank[8'h00] == 8'hA2, "R11 wrap write", bank[8'h00], 8'hA2);
    rd_check(8'hFF, 2, "R11 wrap read");

    // R1 R2 R3 R4 R8 R11: random register bursts
    for (int it = 0; it < 22; it++) begin
      logic [7:0] a;
      int n;
      a = 8'($urandom);
      if (a == 8'h80 || a == 8'h81) a = 8'h7F;
      n = 1 + int'($urandom % 6);
      for (int k = 0; k < n; k++) wdat[k] = 8'($urandom);
      wr_burst(a, n, 1'($urandom));
      rd_check(a, n, "R2 R3 random");
    end

    begin
      int bad = 0;
      for (int i = 0; i < 256; i++) if (bank[i] != exp_bank[i]) bad++;
      check(bad == 0, "R2 R4 bank image", bad, 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule